// File: doc/BRIEF.md
# Debug Command Packet Processor

This block sits between a serial debug link and a halted processor. The link hands it one 17-bit packet per transfer handshake. Each packet is a status bit above a 16-bit data field. Each inbound data field the block is ready for is taken as a command word and decoded. A legal register-read command starts an access on a simple register access port. The port answers with a completion strobe, an optional bus-error flag and a 32-bit value.

Every transfer also returns a response packet at once. There are four kinds of response. A normal result has the status bit clear. A not-ready response, a bus-error response and an illegal-command response all set the status bit and are told apart by a fixed data code. A good 32-bit result goes back over two transfers, upper half first. The second of these transfers also delivers the next command word, so commands can follow each other with no idle transfer between them.

Top module: `dbg_cmd_proc`

## Requirements
- R1: After the synchronous active-high reset `rst`, the response offered on the next transfer is not-ready (`txPacket` = 17'h10000) and `accReq` is low.
- R2: A command word is a legal register read when bits 15:12 = 4'h2, bits 11:8 = 4'h1 and bits 7:4 = 4'h8. Bit 3 selects an address register (1) or a data register (0), and bits 2:0 give the register number. If such a word arrives while `cpuHalted` is high, `accReq` rises on the next cycle with `accIsAddr` = bit 3 and `accRegNum` = bits 2:0.
- R3: Once an access ends with `accDone` high and `accBusErr` low, the first following transfer returns status 0 with `accRdData[31:16]`. The second returns status 0 with `accRdData[15:0]`.
- R4: The transfer that carries the low result half also captures its inbound data as the next command word, with no idle transfer needed.
- R5: While an access is pending (`accReq` high), every transfer returns not-ready (17'h10000). Its inbound data is ignored, and the command stays outstanding until `accDone`.
- R6: If an access ends with `accBusErr` high, the next transfer returns status 1 with data 16'h0001 in place of the result. That transfer also captures the next command word.
- R7: A legal register read received while `cpuHalted` is low starts no access, and the next transfer returns the bus-error response 17'h10001.
- R8: Any command word that is not a legal register read starts no access. The next transfer returns status 1 with data 16'hFFFF and ignores its own inbound data. The block then goes idle, so the transfer after that returns not-ready and takes its data as a new command.
- R9: `accReq` stays high from the start of an access until the cycle in which `accDone` is seen, and drops on the cycle after that.
- R10: Asserting `rst` in the middle of a command drops any pending access and any result still waiting to be sent. The next transfer returns not-ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xferValid | input | 1 | One packet transfer happens on this clock edge |
| rxData | input | 16 | Inbound packet data (command word when one is expected) |
| txPacket | output | 17 | Outbound response packet: bit 16 status, bits 15:0 data |
| cpuHalted | input | 1 | The processor is halted and may be accessed |
| accReq | output | 1 | Register access requested, held until done |
| accIsAddr | output | 1 | Access targets an address register (1) or a data register (0) |
| accRegNum | output | 3 | Register number for the access |
| accRdData | input | 32 | Value returned by the access port with `accDone` |
| accDone | input | 1 | Access port finished the pending access |
| accBusErr | input | 1 | Access ended with a bus error (valid with `accDone`) |

## Verification
Register reads are issued to both address and data registers with several register numbers. Each register in the model holds a distinct value, so the two result halves also show that the fields were decoded and the halves sent in the right order. The not-ready response is driven with a slow access port and a decoy command word sent during the wait. This separates a block that holds its command from one that lets a command be replaced while an access is outstanding. Bus errors, a processor that is not halted, and several illegal words (wrong high, middle or low nibble) each produce their own code. In each case a command sent alongside the error or illegal response shows whether that transfer captures the next opcode or ignores it. Back-to-back reads and a reset in the middle of an access cover the overlap of commands and the recovery from reset.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACCESS,
    ST_RES_HI,
    ST_RES_LO,
    ST_BERR,
    ST_ILLEGAL
  } cmdState_t;

  typedef enum logic [2:0] {
    RSP_NOTREADY,
    RSP_HIGH,
    RSP_LOW,
    RSP_BUSERR,
    RSP_ILLEGAL
  } rspSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    captureOp;
    logic    loadResult;
    rspSel_t rspSel;
  } dpCtl_t;

endpackage

// File: rtl/dbg_datapath.sv
module dbg_datapath
  import dbg_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int RES_W     = 32,
  parameter int REG_NUM_W = 3,
  parameter int PREFIX_W  = DATA_W - REG_NUM_W - 1,
  parameter logic [PREFIX_W-1:0] OP_PREFIX = 12'h218
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpCtl_t               ctl,
  input  logic [DATA_W-1:0]    rxData,
  input  logic [RES_W-1:0]     accRdData,
  output logic                 opLegal,
  output logic                 accIsAddr,
  output logic [REG_NUM_W-1:0] accRegNum,
  output logic [DATA_W:0]      txPacket
);

  localparam int FIELD_W = REG_NUM_W + 1;
  localparam int NUM_SEG = RES_W / DATA_W;

  logic [FIELD_W-1:0] opFields;
  logic [RES_W-1:0]   resultReg;
  logic [DATA_W-1:0]  resultSeg [NUM_SEG];

  // decode of the inbound command word
  assign opLegal = (rxData[DATA_W-1:FIELD_W] == OP_PREFIX);

  always_ff @(posedge clk) begin
    if (rst) begin
      opFields  <= '0;
      resultReg <= '0;
    end else begin
      if (ctl.captureOp)  opFields  <= rxData[FIELD_W-1:0];
      if (ctl.loadResult) resultReg <= accRdData;
    end
  end

  assign accIsAddr = opFields[REG_NUM_W];
  assign accRegNum = opFields[REG_NUM_W-1:0];

  // split the result into transfer-sized segments, index 0 = least significant
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign resultSeg[s] = resultReg[s*DATA_W +: DATA_W];
  end

  always_comb begin
    unique case (ctl.rspSel)
      RSP_HIGH:    txPacket = {1'b0, resultSeg[NUM_SEG-1]};
      RSP_LOW:     txPacket = {1'b0, resultSeg[0]};
      RSP_BUSERR:  txPacket = {1'b1, DATA_W'(1)};
      RSP_ILLEGAL: txPacket = {1'b1, {DATA_W{1'b1}}};
      default:     txPacket = {1'b1, {DATA_W{1'b0}}};
    endcase
  end

endmodule

// File: rtl/dbg_ctrl.sv
module dbg_ctrl
  import dbg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   xferValid,
  input  logic   opLegal,
  input  logic   cpuHalted,
  input  logic   accDone,
  input  logic   accBusErr,
  output dpCtl_t ctl,
  output logic   accReq
);

  cmdState_t state, stateNext, decodeState;
  logic      opSlot;

  // states whose transfer carries the next command word
  assign opSlot = (state == ST_IDLE) || (state == ST_RES_LO) || (state == ST_BERR);

  always_comb begin
    if (!opLegal)       decodeState = ST_ILLEGAL;
    else if (cpuHalted) decodeState = ST_ACCESS;
    else                decodeState = ST_BERR;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE, ST_RES_LO, ST_BERR: if (xferValid) stateNext = decodeState;
      ST_ACCESS:  if (accDone)   stateNext = accBusErr ? ST_BERR : ST_RES_HI;
      ST_RES_HI:  if (xferValid) stateNext = ST_RES_LO;
      ST_ILLEGAL: if (xferValid) stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    ctl.captureOp  = opSlot && xferValid;
    ctl.loadResult = (state == ST_ACCESS) && accDone && !accBusErr;
    unique case (state)
      ST_RES_HI:  ctl.rspSel = RSP_HIGH;
      ST_RES_LO:  ctl.rspSel = RSP_LOW;
      ST_BERR:    ctl.rspSel = RSP_BUSERR;
      ST_ILLEGAL: ctl.rspSel = RSP_ILLEGAL;
      default:    ctl.rspSel = RSP_NOTREADY;
    endcase
  end

  assign accReq = (state == ST_ACCESS);

endmodule

// File: rtl/dbg_cmd_proc.sv
module dbg_cmd_proc
  import dbg_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int RES_W     = 32,
  parameter int REG_NUM_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 xferValid,
  input  logic [DATA_W-1:0]    rxData,
  output logic [DATA_W:0]      txPacket,
  input  logic                 cpuHalted,
  output logic                 accReq,
  output logic                 accIsAddr,
  output logic [REG_NUM_W-1:0] accRegNum,
  input  logic [RES_W-1:0]     accRdData,
  input  logic                 accDone,
  input  logic                 accBusErr
);

  dpCtl_t ctl;
  logic   opLegal;

  dbg_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .xferValid (xferValid),
    .opLegal   (opLegal),
    .cpuHalted (cpuHalted),
    .accDone   (accDone),
    .accBusErr (accBusErr),
    .ctl       (ctl),
    .accReq    (accReq)
  );

  dbg_datapath #(
    .DATA_W    (DATA_W),
    .RES_W     (RES_W),
    .REG_NUM_W (REG_NUM_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .rxData    (rxData),
    .accRdData (accRdData),
    .opLegal   (opLegal),
    .accIsAddr (accIsAddr),
    .accRegNum (accRegNum),
    .txPacket  (txPacket)
  );

endmodule

// File: rtl/dbg_cmd_proc_chk.sv
module dbg_cmd_proc_chk #(
  parameter int DATA_W    = 16,
  parameter int RES_W     = 32,
  parameter int REG_NUM_W = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 xferValid,
  input logic [DATA_W-1:0]    rxData,
  input logic [DATA_W:0]      txPacket,
  input logic                 cpuHalted,
  input logic                 accReq,
  input logic                 accIsAddr,
  input logic [REG_NUM_W-1:0] accRegNum,
  input logic [RES_W-1:0]     accRdData,
  input logic                 accDone,
  input logic                 accBusErr
);

  localparam logic [DATA_W:0] NOT_READY = {1'b1, {DATA_W{1'b0}}};
  localparam logic [DATA_W:0] BUS_ERR   = {1'b1, DATA_W'(1)};
  localparam logic [DATA_W:0] ILLEGAL   = {1'b1, {DATA_W{1'b1}}};

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (txPacket == NOT_READY && !accReq));

  a_r5_notready_pending: assert property (@(posedge clk) disable iff (rst)
    accReq |-> (txPacket == NOT_READY));

  a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
    (accReq && !accDone) |=> accReq);

  a_r9_req_drops: assert property (@(posedge clk) disable iff (rst)
    (accReq && accDone) |=> !accReq);

  a_r3_good_status: assert property (@(posedge clk) disable iff (rst)
    (accReq && accDone && !accBusErr) |=> (txPacket[DATA_W] == 1'b0));

  a_r6_berr_code: assert property (@(posedge clk) disable iff (rst)
    (accReq && accDone && accBusErr) |=> (txPacket == BUS_ERR));

  a_r8_illegal_to_idle: assert property (@(posedge clk) disable iff (rst)
    (xferValid && txPacket == ILLEGAL) |=> (!accReq && txPacket == NOT_READY));

endmodule

bind dbg_cmd_proc dbg_cmd_proc_chk #(
  .DATA_W    (DATA_W),
  .RES_W     (RES_W),
  .REG_NUM_W (REG_NUM_W)
) u_chk (.*);

// File: tb/sim_dbg_cmd_proc.sv
module sim_dbg_cmd_proc;

  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] NOT_READY = 17'h10000;
  localparam logic [16:0] BUS_ERR   = 17'h10001;
  localparam logic [16:0] ILLEGAL   = 17'h1FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xferValid = 1'b0;
  logic [15:0] rxData = '0;
  logic [16:0] txPacket;
  logic        cpuHalted = 1'b1;
  logic        accReq;
  logic        accIsAddr;
  logic [2:0]  accRegNum;
  logic [31:0] accRdData = '0;
  logic        accDone = 1'b0;
  logic        accBusErr = 1'b0;

  int checks = 0;
  int failures = 0;
  int lat = 2;
  logic berrMode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_proc u0 (
    .clk(clk), .rst(rst), .xferValid(xferValid), .rxData(rxData),
    .txPacket(txPacket), .cpuHalted(cpuHalted), .accReq(accReq),
    .accIsAddr(accIsAddr), .accRegNum(accRegNum), .accRdData(accRdData),
    .accDone(accDone), .accBusErr(accBusErr)
  );

  // register contents of the processor model
  function automatic logic [31:0] regVal(input logic isA, input logic [2:0] n);
    return {isA ? 4'hA : 4'hD, 1'b0, n, 24'h3C5A96 ^ {21'b0, n}};
  endfunction

  function automatic logic [15:0] rdCmd(input logic isA, input logic [2:0] n);
    return {12'h218, isA, n};
  endfunction

  // access port model: answers after lat waiting cycles
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      accDone = 1'b0;
      accBusErr = 1'b0;
      if (accReq) begin
        if (waitCnt >= lat) begin
          accDone = 1'b1;
          accBusErr = berrMode;
          accRdData = regVal(accIsAddr, accRegNum);
          waitCnt = 0;
        end else waitCnt++;
      end else waitCnt = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] cmd, output logic [16:0] resp);
    @(negedge clk);
    rxData = cmd;
    xferValid = 1'b1;
    #1 resp = txPacket;
    @(posedge clk);
    #1;
    xferValid = 1'b0;
    rxData = '0;
  endtask

  task automatic waitAccess();
    repeat (lat + 3) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset response", {15'b0, txPacket}, {15'b0, NOT_READY});
    chk("R1 reset accReq", {31'b0, accReq}, 32'h0);
  endtask

  // single read: command then two result transfers
  task automatic t_read(input logic isA, input logic [2:0] n);
    logic [16:0] r;
    xfer(rdCmd(isA, n), r);
    chk("R2 idle response", {15'b0, r}, {15'b0, NOT_READY});
    #1;
    chk("R2 accReq", {31'b0, accReq}, 32'h1);
    chk("R2 accIsAddr", {31'b0, accIsAddr}, {31'b0, isA});
    chk("R2 accRegNum", {29'b0, accRegNum}, {29'b0, n});
    waitAccess();
    xfer(16'h0000, r);
    chk("R3 high half", {15'b0, r}, {15'b0, 1'b0, regVal(isA, n)[31:16]});
    xfer(16'h0000, r);
    chk("R3 low half", {15'b0, r}, {15'b0, 1'b0, regVal(isA, n)[15:0]});
    // 16'h0000 captured as illegal command: drain it
    xfer(16'h0000, r);
    chk("R8 illegal after zero word", {15'b0, r}, {15'b0, ILLEGAL});
  endtask

  task automatic t_notready();
    logic [16:0] r;
    lat = 8;
    xfer(rdCmd(1'b0, 3'd6), r);
    xfer(rdCmd(1'b1, 3'd1), r);   // decoy while pending
    chk("R5 pending response", {15'b0, r}, {15'b0, NOT_READY});
    xfer(16'hFFFF, r);
    chk("R5 pending response 2", {15'b0, r}, {15'b0, NOT_READY});
    #1;
    chk("R5 command kept", {28'b0, accIsAddr, accRegNum}, {28'b0, 1'b0, 3'd6});
    waitAccess();
    xfer(16'h0000, r);
    chk("R5 result high after wait", {15'b0, r}, {15'b0, 1'b0, regVal(1'b0, 3'd6)[31:16]});
    xfer(16'h0000, r);
    xfer(16'h0000, r);
    lat = 2;
  endtask

  task automatic t_backtoback();
    logic [16:0] r;
    xfer(rdCmd(1'b1, 3'd5), r);
    waitAccess();
    xfer(16'h0000, r);
    xfer(rdCmd(1'b0, 3'd2), r);   // next command rides on low half
    chk("R4 low half with next cmd", {15'b0, r}, {15'b0, 1'b0, regVal(1'b1, 3'd5)[15:0]});
    #1;
    chk("R4 next access started", {27'b0, accReq, accIsAddr, accRegNum}, {27'b0, 1'b1, 1'b0, 3'd2});
    waitAccess();
    xfer(16'h0000, r);
    chk("R4 next result high", {15'b0, r}, {15'b0, 1'b0, regVal(1'b0, 3'd2)[31:16]});
    xfer(16'h0000, r);
    chk("R4 next result low", {15'b0, r}, {15'b0, 1'b0, regVal(1'b0, 3'd2)[15:0]});
    xfer(16'h0000, r);
  endtask

  task automatic t_buserr();
    logic [16:0] r;
    berrMode = 1'b1;
    xfer(rdCmd(1'b0, 3'd4), r);
    waitAccess();
    berrMode = 1'b0;
    xfer(rdCmd(1'b1, 3'd7), r);
    chk("R6 bus error code", {15'b0, r}, {15'b0, BUS_ERR});
    #1;
    chk("R6 next cmd captured", {27'b0, accReq, accIsAddr, accRegNum}, {27'b0, 1'b1, 1'b1, 3'd7});
    waitAccess();
    xfer(16'h0000, r);
    chk("R6 following result high", {15'b0, r}, {15'b0, 1'b0, regVal(1'b1, 3'd7)[31:16]});
    xfer(16'h0000, r);
    xfer(16'h0000, r);
  endtask

  task automatic t_nothalted();
    logic [16:0] r;
    cpuHalted = 1'b0;
    xfer(rdCmd(1'b0, 3'd1), r);
    #1;
    chk("R7 no access when running", {31'b0, accReq}, 32'h0);
    cpuHalted = 1'b1;
    xfer(rdCmd(1'b0, 3'd3), r);
    chk("R7 bus error response", {15'b0, r}, {15'b0, BUS_ERR});
    waitAccess();
    xfer(16'h0000, r);
    chk("R7 captured cmd result", {15'b0, r}, {15'b0, 1'b0, regVal(1'b0, 3'd3)[31:16]});
    xfer(16'h0000, r);
    xfer(16'h0000, r);
  endtask

  task automatic t_illegal(input logic [15:0] bad);
    logic [16:0] r;
    xfer(bad, r);
    #1;
    chk("R8 no access for illegal", {31'b0, accReq}, 32'h0);
    xfer(rdCmd(1'b1, 3'd2), r);    // ignored during illegal response
    chk("R8 illegal code", {15'b0, r}, {15'b0, ILLEGAL});
    #1;
    chk("R8 data ignored", {31'b0, accReq}, 32'h0);
    xfer(rdCmd(1'b1, 3'd2), r);
    chk("R8 idle after illegal", {15'b0, r}, {15'b0, NOT_READY});
    #1;
    chk("R8 new command accepted", {31'b0, accReq}, 32'h1);
    waitAccess();
    xfer(16'h0000, r);
    xfer(16'h0000, r);
    xfer(16'h0000, r);
  endtask

  task automatic t_midreset();
    logic [16:0] r;
    lat = 10;
    xfer(rdCmd(1'b1, 3'd0), r);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 access dropped", {31'b0, accReq}, 32'h0);
    chk("R10 response not ready", {15'b0, txPacket}, {15'b0, NOT_READY});
    lat = 2;
    // result pending then reset
    xfer(rdCmd(1'b0, 3'd5), r);
    waitAccess();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    xfer(16'h0000, r);
    chk("R10 pending result discarded", {15'b0, r}, {15'b0, NOT_READY});
    xfer(16'h0000, r);
  endtask

  task automatic t_reqhold();
    logic ok = 1'b1;
    logic [16:0] r;
    lat = 5;
    xfer(rdCmd(1'b0, 3'd0), r);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #1 if (!accReq) ok = 1'b0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R9 req held while waiting", {31'b0, ok}, 32'h1);
    chk("R9 req dropped after done", {31'b0, accReq}, 32'h0);
    xfer(16'h0000, r);
    xfer(16'h0000, r);
    xfer(16'h0000, r);
    lat = 2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_read(1'b0, 3'd3);
    t_read(1'b1, 3'd5);
    t_read(1'b0, 3'd7);
    t_notready();
    t_backtoback();
    t_buserr();
    t_nothalted();
    t_illegal(16'h3180);
    t_illegal(16'h2280);
    t_illegal(16'h2190);
    t_reqhold();
    t_midreset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule